// File: doc/BRIEF.md
# Eight-Bit Arithmetic Unit with Status Flags

This block is the datapath arithmetic unit of a small eight-bit processor core. The requester hands it one operation at a time: an operation code, a first operand, a second operand (taken from a register value or from an immediate byte), and an immediate. The unit computes the result in one pass. The result goes into a one-entry output stage. In the same clock edge, the six-bit status register is updated.

Each operation class changes only its own subset of the status bits. Every other status bit keeps its value, so a later carry-chained operation sees the carry left by an earlier one. Two-byte subtract and compare chains work because the zero flag is sticky in the carry-using subtract forms. A word operation adds or subtracts a six-bit immediate to a sixteen-bit register pair and returns both bytes.

The input side is valid/ready. An operation is taken on a clock edge when `in_valid` and `in_ready` are both high. The output side is also valid/ready. The result stays on `out_*`, unchanged, until `out_ready` is seen high with `out_valid`. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle, so a stalled consumer stops new operations. The status register therefore changes only when an operation is actually taken.

Top module: `alu8_core`

## Requirements
- R1: During and right after reset, `out_valid` is 0, `in_ready` is 1 and all six status bits read 0. The status bit positions are: bit 0 carry C, bit 1 zero Z, bit 2 negative N, bit 3 overflow V, bit 4 sign S, bit 5 half carry H.
- R2: Add (code 0), add with carry (1), subtract (2) and subtract with carry (3) produce the 8-bit result and update C, Z, N, V and H. C is the carry or borrow out of bit 7, and H is the carry or borrow out of bit 3. The carry-using forms use the C bit held before the operation.
- R3: AND (4), OR (5) and XOR (6) update Z and N, force V to 0, and leave C and H unchanged.
- R4: One's complement (7) returns 0xFF minus the operand, sets C to 1, clears V, and updates Z and N. Two's complement (8) returns 0x00 minus the operand, sets C when the operand is non-zero, sets V only for 0x80, and updates H, Z and N.
- R5: Increment (9) and decrement (10) update Z, N and V, where V marks the signed wrap. C and H are never changed.
- R6: Shift left (11), shift right (12), rotate left through carry (13), rotate right through carry (14) and arithmetic shift right (15) update C, Z, N and V. C takes the bit shifted out, and V equals the new N XOR the new C. Arithmetic shift right keeps bit 7 unchanged.
- R7: Nibble swap (16) and load 0xFF (17) change no status bit. Codes 22 to 31 also change no status bit, return operand `in_a`, and report `out_wr` = 0.
- R8: Compare (18) and compare with carry (19) update the flags exactly as subtract and subtract with carry do, and report `out_wr` = 0. Every defined code other than 18 and 19 reports `out_wr` = 1.
- R9: For subtract with carry and compare with carry, Z can only stay 1 or become 0. Z ends at 1 only if the result is zero and Z was already 1.
- R10: Word add (20) and word subtract (21) operate on the pair {`in_b`, `in_a`} (high, low) with the immediate `in_imm[5:0]`; `in_imm[7:6]` and `in_use_imm` have no effect. The result is returned on {`out_res_hi`, `out_res`}. They update C, Z, N, V and S from the 16-bit result and leave H unchanged. For byte operations, `out_res_hi` is 0.
- R11: Whenever an operation updates N or V, S becomes N XOR V.
- R12: `in_ready` equals NOT `out_valid` OR `out_ready`. While `out_valid` is high and `out_ready` is low, the outputs hold steady. The status register changes only on an accepted operation, and each accepted operation yields exactly one output in order.
- R13: With `in_use_imm` = 1, the second byte operand is `in_imm` and `in_b` has no effect. With `in_use_imm` = 0, the second byte operand is `in_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 5 | Operation code |
| in_a | input | 8 | First operand, low byte of the pair for word operations |
| in_b | input | 8 | Second register operand, high byte of the pair for word operations |
| in_imm | input | 8 | Immediate byte |
| in_use_imm | input | 1 | Select the immediate as the second byte operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 8 | Result, low byte for word operations |
| out_res_hi | output | 8 | High byte of a word result, 0 otherwise |
| out_wr | output | 1 | Result is meant to be written back |
| flags | output | 6 | Status register {H,S,V,N,Z,C} |

## Verification
The bench aims at the overflow and carry boundaries: 0x7F+1, 0xFF+1, 0x00-1, two's complement of 0x80 and 0x00, increment of 0x7F, decrement of 0x80, and the word wraps at 0xFFFF and 0x8000. A design that takes carry or half carry from the wrong bit, or that computes overflow from unsigned values, shows wrong C, H or V on these operands. The bench chains compare with carry and subtract with carry so that Z must persist or drop in turn; a design that recomputes Z from the result alone would report equality after a non-equal upper byte. It also checks that logic, increment, swap and undefined codes leave the untouched flags unchanged, that `in_imm[7:6]` does not affect word operations, and that back-pressure neither drops nor repeats a result nor moves the flags.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int unsigned ALU_DW = 8;
  localparam int unsigned WK_W   = 6;
  localparam int unsigned OPW    = 5;
  localparam int unsigned FLW    = 6;

  typedef enum logic [OPW-1:0] {
    OP_ADD   = 5'd0,
    OP_ADC   = 5'd1,
    OP_SUB   = 5'd2,
    OP_SBC   = 5'd3,
    OP_AND   = 5'd4,
    OP_OR    = 5'd5,
    OP_XOR   = 5'd6,
    OP_COM   = 5'd7,
    OP_NEG   = 5'd8,
    OP_INC   = 5'd9,
    OP_DEC   = 5'd10,
    OP_LSL   = 5'd11,
    OP_LSR   = 5'd12,
    OP_ROL   = 5'd13,
    OP_ROR   = 5'd14,
    OP_ASR   = 5'd15,
    OP_SWAP  = 5'd16,
    OP_SETFF = 5'd17,
    OP_CMP   = 5'd18,
    OP_CPC   = 5'd19,
    OP_WADD  = 5'd20,
    OP_WSUB  = 5'd21
  } alu_op_e;

  // Packed so that c lands in bit 0 and h in bit 5.
  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;

  function automatic flags_t flag_mask(alu_op_e op);
    flags_t m;
    m = '0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CPC, OP_NEG:
        m = '{h: 1'b1, s: 1'b1, v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1};
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC:
        m = '{h: 1'b0, s: 1'b1, v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b0};
      OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR, OP_WADD, OP_WSUB:
        m = '{h: 1'b0, s: 1'b1, v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1};
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic op_is_arith(alu_op_e op);
    return op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CPC,
                      OP_NEG, OP_INC, OP_DEC};
  endfunction

  function automatic logic op_is_shift(alu_op_e op);
    return op inside {OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR};
  endfunction

  function automatic logic op_is_logic(alu_op_e op);
    return op inside {OP_AND, OP_OR, OP_XOR};
  endfunction

  function automatic logic op_is_word(alu_op_e op);
    return op inside {OP_WADD, OP_WSUB};
  endfunction

  function automatic logic op_sticky_z(alu_op_e op);
    return op inside {OP_SBC, OP_CPC};
  endfunction

  function automatic logic op_writes(alu_op_e op);
    return (op <= OP_WSUB) && !(op inside {OP_CMP, OP_CPC});
  endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] sum_o,
  output logic          c_o,
  output logic          h_o,
  output logic          v_o
);
  localparam int unsigned HB = DW / 2;

  logic [DW-1:0] bx;
  logic          ci;
  logic [DW:0]   full;
  logic [HB:0]   part;

  // Subtraction is a + ~b + ~borrow; the carries are inverted back to borrows.
  always_comb begin
    bx    = sub_i ? ~b_i : b_i;
    ci    = sub_i ? ~cin_i : cin_i;
    full  = {1'b0, a_i} + {1'b0, bx} + {{DW{1'b0}}, ci};
    part  = {1'b0, a_i[HB-1:0]} + {1'b0, bx[HB-1:0]} + {{HB{1'b0}}, ci};
    sum_o = full[DW-1:0];
    c_o   = full[DW] ^ sub_i;
    h_o   = part[HB] ^ sub_i;
    v_o   = (a_i[DW-1] == bx[DW-1]) && (full[DW-1] != a_i[DW-1]);
  end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output logic          c_o
);
  localparam int unsigned HB = DW / 2;

  always_comb begin
    res_o = a_i;
    c_o   = cin_i;
    case (op_i)
      OP_AND:   res_o = a_i & b_i;
      OP_OR:    res_o = a_i | b_i;
      OP_XOR:   res_o = a_i ^ b_i;
      OP_COM: begin
        res_o = ~a_i;
        c_o   = 1'b1;
      end
      OP_LSL: begin
        res_o = {a_i[DW-2:0], 1'b0};
        c_o   = a_i[DW-1];
      end
      OP_LSR: begin
        res_o = {1'b0, a_i[DW-1:1]};
        c_o   = a_i[0];
      end
      OP_ROL: begin
        res_o = {a_i[DW-2:0], cin_i};
        c_o   = a_i[DW-1];
      end
      OP_ROR: begin
        res_o = {cin_i, a_i[DW-1:1]};
        c_o   = a_i[0];
      end
      OP_ASR: begin
        res_o = {a_i[DW-1], a_i[DW-1:1]};
        c_o   = a_i[0];
      end
      OP_SWAP:  res_o = {a_i[HB-1:0], a_i[DW-1:HB]};
      OP_SETFF: res_o = '1;
      default:  res_o = a_i;
    endcase
  end

endmodule

// File: rtl/alu8_word.sv
module alu8_word #(
  parameter int unsigned DW = 8,
  parameter int unsigned KW = 6
) (
  input  logic [DW-1:0]   lo_i,
  input  logic [DW-1:0]   hi_i,
  input  logic [KW-1:0]   k_i,
  input  logic            sub_i,
  output logic [2*DW-1:0] res_o,
  output logic            c_o,
  output logic            v_o
);
  localparam int unsigned PW = 2 * DW;

  logic [PW:0] pair_x;
  logic [PW:0] k_x;
  logic [PW:0] full;

  always_comb begin
    pair_x = {1'b0, hi_i, lo_i};
    k_x    = {{(PW + 1 - KW){1'b0}}, k_i};
    full   = sub_i ? (pair_x - k_x) : (pair_x + k_x);
    res_o  = full[PW-1:0];
    c_o    = full[PW];
    // The immediate is non-negative, so overflow is a sign change in one direction only.
    v_o    = sub_i ? (hi_i[DW-1] & ~full[PW-1]) : (~hi_i[DW-1] & full[PW-1]);
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned DW = ALU_DW,
  parameter int unsigned KW = WK_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [OPW-1:0] in_op,
  input  logic [DW-1:0]  in_a,
  input  logic [DW-1:0]  in_b,
  input  logic [DW-1:0]  in_imm,
  input  logic           in_use_imm,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_res,
  output logic [DW-1:0]  out_res_hi,
  output logic           out_wr,
  output logic [FLW-1:0] flags
);

  alu_op_e         op;
  logic            in_fire;
  logic [DW-1:0]   b_eff;
  flags_t          flag_q;
  flags_t          flag_d;
  flags_t          cand;
  flags_t          mask;

  logic [DW-1:0]   as_a;
  logic [DW-1:0]   as_b;
  logic            as_cin;
  logic            as_sub;
  logic [DW-1:0]   as_sum;
  logic            as_c;
  logic            as_h;
  logic            as_v;

  logic [DW-1:0]   bo_res;
  logic            bo_c;

  logic [2*DW-1:0] wd_res;
  logic            wd_c;
  logic            wd_v;

  logic [DW-1:0]   res_lo;
  logic [DW-1:0]   res_hi;
  logic            zero_raw;

  logic            out_valid_q;
  logic [DW-1:0]   out_res_q;
  logic [DW-1:0]   out_res_hi_q;
  logic            out_wr_q;

  assign op       = alu_op_e'(in_op);
  assign b_eff    = in_use_imm ? in_imm : in_b;
  assign in_ready = !out_valid_q || out_ready;
  assign in_fire  = in_valid && in_ready;

  // Operand routing for the shared adder.
  always_comb begin
    as_a   = in_a;
    as_b   = b_eff;
    as_cin = 1'b0;
    as_sub = 1'b0;
    case (op)
      OP_ADC:                 as_cin = flag_q.c;
      OP_SUB, OP_CMP:         as_sub = 1'b1;
      OP_SBC, OP_CPC: begin
        as_sub = 1'b1;
        as_cin = flag_q.c;
      end
      OP_NEG: begin
        as_a   = '0;
        as_b   = in_a;
        as_sub = 1'b1;
      end
      OP_INC:                 as_b = {{(DW-1){1'b0}}, 1'b1};
      OP_DEC: begin
        as_b   = {{(DW-1){1'b0}}, 1'b1};
        as_sub = 1'b1;
      end
      default: ;
    endcase
  end

  alu8_addsub #(.DW(DW)) u_addsub (
    .a_i   (as_a),
    .b_i   (as_b),
    .cin_i (as_cin),
    .sub_i (as_sub),
    .sum_o (as_sum),
    .c_o   (as_c),
    .h_o   (as_h),
    .v_o   (as_v)
  );

  alu8_bitops #(.DW(DW)) u_bitops (
    .op_i  (op),
    .a_i   (in_a),
    .b_i   (b_eff),
    .cin_i (flag_q.c),
    .res_o (bo_res),
    .c_o   (bo_c)
  );

  alu8_word #(.DW(DW), .KW(KW)) u_word (
    .lo_i  (in_a),
    .hi_i  (in_b),
    .k_i   (in_imm[KW-1:0]),
    .sub_i (op == OP_WSUB),
    .res_o (wd_res),
    .c_o   (wd_c),
    .v_o   (wd_v)
  );

  // Candidate flags from the selected unit, then merged under the per-op mask.
  always_comb begin
    cand     = '0;
    res_lo   = bo_res;
    res_hi   = '0;
    zero_raw = 1'b0;
    if (op_is_word(op)) begin
      res_lo   = wd_res[DW-1:0];
      res_hi   = wd_res[2*DW-1:DW];
      cand.c   = wd_c;
      cand.v   = wd_v;
      cand.n   = wd_res[2*DW-1];
      zero_raw = (wd_res == '0);
    end else if (op_is_arith(op)) begin
      res_lo   = as_sum;
      cand.c   = as_c;
      cand.h   = as_h;
      cand.v   = as_v;
      cand.n   = as_sum[DW-1];
      zero_raw = (as_sum == '0);
    end else begin
      cand.c   = bo_c;
      cand.n   = bo_res[DW-1];
      cand.v   = op_is_shift(op) ? (bo_res[DW-1] ^ bo_c) : 1'b0;
      zero_raw = (bo_res == '0);
    end
    cand.z = zero_raw & (op_sticky_z(op) ? flag_q.z : 1'b1);
    cand.s = cand.n ^ cand.v;
    mask   = flag_mask(op);
    flag_d = flags_t'((mask & cand) | (~mask & flag_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q       <= '0;
      out_valid_q  <= 1'b0;
      out_res_q    <= '0;
      out_res_hi_q <= '0;
      out_wr_q     <= 1'b0;
    end else if (in_fire) begin
      flag_q       <= flag_d;
      out_valid_q  <= 1'b1;
      out_res_q    <= res_lo;
      out_res_hi_q <= res_hi;
      out_wr_q     <= op_writes(op);
    end else if (out_ready) begin
      out_valid_q  <= 1'b0;
    end
  end

  assign out_valid  = out_valid_q;
  assign out_res    = out_res_q;
  assign out_res_hi = out_res_hi_q;
  assign out_wr     = out_wr_q;
  assign flags      = flag_q;

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_res) && $stable(out_res_hi) && $stable(out_wr)));

  // R12
  flags_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(flags));

  // R11
  sign_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags[4] == (flags[2] ^ flags[3]));

  // R5
  incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && (in_op == 5'd9 || in_op == 5'd10)) |=>
      (flags[0] == $past(flags[0]) && flags[5] == $past(flags[5])));

  // R3
  logic_v_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && (in_op == 5'd4 || in_op == 5'd5 || in_op == 5'd6)) |=>
      (!flags[3] && flags[0] == $past(flags[0])));

  // R8
  compare_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && (in_op == 5'd18 || in_op == 5'd19)) |=> !out_wr);

  // R7
  swap_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && (in_op == 5'd16 || in_op == 5'd17 || in_op > 5'd21)) |=> $stable(flags));

endmodule

// File: tb/test_alu8_core.sv
module test_alu8_core;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [4:0] in_op = '0;
  logic [7:0] in_a = '0;
  logic [7:0] in_b = '0;
  logic [7:0] in_imm = '0;
  logic       in_use_imm = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_res;
  logic [7:0] out_res_hi;
  logic       out_wr;
  logic [5:0] flags;

  int n_vec  = 0;
  int n_fail = 0;
  int rdy_mode = 0;
  bit finished = 0;

  logic [5:0] mflags = '0;
  string      last_tag = "R1";
  int         q_r[$];
  int         q_h[$];
  int         q_w[$];
  string      q_t[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core i_alu8_core (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_imm(in_imm), .in_use_imm(in_use_imm),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_res_hi(out_res_hi), .out_wr(out_wr), .flags(flags)
  );

  function automatic string rtag(int op);
    if (op <= 3) return "R2";
    if (op <= 6) return "R3";
    if (op <= 8) return "R4";
    if (op <= 10) return "R5";
    if (op <= 15) return "R6";
    if (op <= 17) return "R7";
    if (op <= 19) return "R8";
    if (op <= 21) return "R10";
    return "R7";
  endfunction

  function automatic int sx(int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  // Behavioural reference: integer arithmetic, flags from their definitions.
  function automatic void model(input int op, input int a, input int b, input int imm,
                                input int ui, input logic [5:0] fin,
                                output int r, output int rh, output int wr,
                                output logic [5:0] fout);
    int bb, cc, t, sv, p, k, r16;
    logic c, z, n, v, s, h, c0, upd;
    c = fin[0]; z = fin[1]; n = fin[2]; v = fin[3]; s = fin[4]; h = fin[5];
    c0 = c; upd = 1'b1;
    bb = ui ? imm : b;  // R13
    r = a; rh = 0; wr = 1;
    case (op)
      0, 1, 2, 3, 18, 19: begin
        cc = (op == 1 || op == 3 || op == 19) ? int'(c0) : 0;
        if (op <= 1) begin
          t = a + bb + cc; c = (t > 255); h = ((a % 16) + (bb % 16) + cc) > 15;
          sv = sx(a) + sx(bb) + cc;
        end else begin
          t = a - bb - cc; c = (t < 0); h = ((a % 16) - (bb % 16) - cc) < 0;
          sv = sx(a) - sx(bb) - cc;
        end
        r = t & 255; v = (sv > 127) || (sv < -128); n = (r >= 128);
        // R9: sticky zero for the carry-using subtract forms
        z = (op == 3 || op == 19) ? (z && r == 0) : (r == 0);
        if (op >= 18) wr = 0;
      end
      4, 5, 6: begin
        r = (op == 4) ? (a & bb) : (op == 5) ? (a | bb) : (a ^ bb);
        v = 0; n = (r >= 128); z = (r == 0);
      end
      7: begin r = 255 - a; c = 1; v = 0; n = (r >= 128); z = (r == 0); end
      8: begin
        r = (256 - a) & 255; c = (a != 0); h = ((a % 16) != 0); v = (a == 128);
        n = (r >= 128); z = (r == 0);
      end
      9:  begin r = (a + 1) & 255; v = (a == 127); n = (r >= 128); z = (r == 0); end
      10: begin r = (a + 255) & 255; v = (a == 128); n = (r >= 128); z = (r == 0); end
      11, 12, 13, 14, 15: begin
        case (op)
          11: begin r = (a * 2) & 255; c = (a >= 128); end
          12: begin r = a / 2; c = (a % 2) == 1; end
          13: begin r = ((a * 2) & 255) + int'(c0); c = (a >= 128); end
          14: begin r = a / 2 + (c0 ? 128 : 0); c = (a % 2) == 1; end
          default: begin r = a / 2 + (a & 128); c = (a % 2) == 1; end
        endcase
        n = (r >= 128); z = (r == 0); v = n ^ c;
      end
      16: begin r = (a % 16) * 16 + a / 16; upd = 0; end
      17: begin r = 255; upd = 0; end
      20, 21: begin
        p = b * 256 + a; k = imm % 64;
        if (op == 20) begin
          t = p + k; c = (t > 65535); r16 = t & 65535; v = (p < 32768) && (r16 >= 32768);
        end else begin
          t = p - k; c = (t < 0); r16 = t & 65535; v = (p >= 32768) && (r16 < 32768);
        end
        r = r16 & 255; rh = r16 / 256; n = (r16 >= 32768); z = (r16 == 0);
      end
      default: begin r = a; wr = 0; upd = 0; end
    endcase
    if (upd) s = n ^ v;  // R11
    fout = {h, s, v, n, z, c};
  endfunction

  task automatic fail_line(string tag, string what, int act, int exp);
    n_fail++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  task automatic cycle(input bit v, input int op, input int a, input int b,
                       input int imm, input int ui, output bit took);
    int r, rh, wr;
    logic [5:0] nf;
    @(negedge clk);
    out_ready = (rdy_mode == 0) ? 1'b1 : ($urandom_range(0, 2) != 0);
    in_valid = v; in_op = op[4:0]; in_a = a[7:0]; in_b = b[7:0];
    in_imm = imm[7:0]; in_use_imm = ui[0];
    #1;
    n_vec++;
    if (flags !== mflags) fail_line(last_tag, "flags", flags, mflags);
    n_vec++;
    if (out_valid !== (q_r.size() != 0)) fail_line("R12", "out_valid", out_valid, q_r.size() != 0);
    n_vec++;
    if (in_ready !== (!out_valid || out_ready)) fail_line("R12", "in_ready", in_ready, !out_valid || out_ready);
    if (out_valid && out_ready && q_r.size() != 0) begin
      int er, eh, ew; string et;
      er = q_r.pop_front(); eh = q_h.pop_front(); ew = q_w.pop_front(); et = q_t.pop_front();
      n_vec++;
      if (out_res !== er[7:0]) fail_line(et, "out_res", out_res, er);
      n_vec++;
      if (out_res_hi !== eh[7:0]) fail_line(et, "out_res_hi", out_res_hi, eh);
      n_vec++;
      if (out_wr !== ew[0]) fail_line(et, "out_wr", out_wr, ew);
    end
    took = in_valid && in_ready;
    if (took) begin
      model(op, a, b, imm, ui, mflags, r, rh, wr, nf);
      q_r.push_back(r); q_h.push_back(rh); q_w.push_back(wr); q_t.push_back(rtag(op));
      mflags = nf;
      last_tag = rtag(op);
    end
  endtask

  task automatic send(input int op, input int a, input int b, input int imm, input int ui);
    bit took;
    do cycle(1, op, a, b, imm, ui, took); while (!took);
  endtask

  task automatic idle(input int n);
    bit took;
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, 0, took);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    n_vec++;
    if (out_valid !== 1'b0) fail_line("R1", "out_valid", out_valid, 0);
    n_vec++;
    if (in_ready !== 1'b1) fail_line("R1", "in_ready", in_ready, 1);
    n_vec++;
    if (flags !== 6'h00) fail_line("R1", "flags", flags, 0);
    rst_n = 1'b1;
    idle(2);

    // R2 boundaries
    send(0, 8'h7F, 8'h01, 0, 0);
    send(0, 8'hFF, 8'h01, 0, 0);
    send(1, 8'h10, 8'h20, 0, 0);
    send(2, 8'h00, 8'h01, 0, 0);
    send(3, 8'h80, 8'h00, 0, 0);
    // R13: immediate replaces b
    send(0, 8'h05, 8'hAA, 8'h03, 1);
    send(2, 8'h05, 8'hAA, 8'h05, 1);
    // R9: chained equality, then a non-equal upper byte
    send(18, 8'h00, 8'h00, 0, 0);
    send(19, 8'h12, 8'h12, 0, 0);
    send(19, 8'h13, 8'h12, 0, 0);
    send(3, 8'h01, 8'h01, 0, 0);
    send(18, 8'h40, 8'h40, 0, 0);
    send(3, 8'h02, 8'h01, 0, 0);
    // R3, R4, R5
    send(0, 8'hFF, 8'h01, 0, 0);
    send(4, 8'hF0, 8'h0F, 0, 0);
    send(6, 8'h80, 8'h01, 0, 0);
    send(7, 8'h00, 0, 0, 0);
    send(8, 8'h80, 0, 0, 0);
    send(8, 8'h00, 0, 0, 0);
    send(9, 8'h7F, 0, 0, 0);
    send(10, 8'h80, 0, 0, 0);
    send(10, 8'h00, 0, 0, 0);
    // R6
    send(12, 8'h01, 0, 0, 0);
    send(13, 8'h80, 0, 0, 0);
    send(14, 8'h02, 0, 0, 0);
    send(15, 8'h81, 0, 0, 0);
    send(11, 8'h40, 0, 0, 0);
    // R7
    send(16, 8'hA5, 0, 0, 0);
    send(17, 8'h00, 0, 0, 0);
    send(25, 8'h3C, 8'h11, 0, 0);
    // R10: wraps and ignored upper immediate bits
    send(20, 8'hFF, 8'hFF, 8'h01, 0);
    send(20, 8'hFF, 8'h7F, 8'hC1, 1);
    send(21, 8'h00, 8'h80, 8'h01, 0);
    send(21, 8'h00, 8'h00, 8'h01, 0);
    send(21, 8'h05, 8'h00, 8'h45, 0);

    // R12: random traffic under back-pressure
    for (int pass = 0; pass < 2; pass++) begin
      rdy_mode = pass;
      for (int i = 0; i < 2500; i++) begin
        bit took;
        int op;
        op = $urandom_range(0, 23);
        cycle($urandom_range(0, 3) != 0, op, $urandom_range(0, 255), $urandom_range(0, 255),
              $urandom_range(0, 255), $urandom_range(0, 1), took);
      end
    end
    rdy_mode = 0;
    idle(4);
    n_vec++;
    if (q_r.size() != 0) fail_line("R12", "pending results", q_r.size(), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule